// File: doc/BRIEF.md
# Event Interrupt and Soft-Reset Controller

This block sits beside a serial-peripheral core. It turns the core's single-cycle event pulses into one level-sensitive interrupt request and gives software a keyed way to restart the core. Each of six event sources has a sticky status bit. A status bit is set by its event pulse and cleared by writing a one to it. A per-source enable mask and one global enable decide whether a pending source drives the interrupt line.

Software reaches the block through a simple register port: a write strobe with address and data, and combinational read data for the address on the port. The global enable sits at offset 0x1C, the sticky status at 0x20, the per-source mask at 0x28 and the restart key register at 0x40. Writing the key value 0x0A to the restart register sends a one-cycle restart pulse to the core. The same write wipes the status and mask registers.

Top module: `evt_irq_ctl`

## Requirements
- R1: After the synchronous active-high reset, the status, mask and global enable registers read zero, and the interrupt and restart outputs are low.
- R2: An event pulse sets its status bit on the next clock edge, whatever the mask holds. Event bit positions are 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive full, 5 receive overrun. Status reads in bits 5:0 at offset 0x20.
- R3: A write to 0x20 clears exactly the status bits written as one and leaves the others unchanged, so writing back a value that was read clears just those bits.
- R4: When an event pulse and a clearing write hit the same bit in one cycle, the bit ends up set.
- R5: The interrupt output is a level equal to the global enable ANDed with the OR over all sources of (status AND mask). The mask is written and read in bits 5:0 at offset 0x28.
- R6: While the global enable (bit 31 at offset 0x1C) is clear, the interrupt output stays low.
- R7: Writing exactly 0x0000000A to offset 0x40 raises the restart output for the one cycle after that write's clock edge.
- R8: The key write clears the status and mask registers at its own clock edge, overriding any event in that cycle. It leaves the global enable unchanged.
- R9: Writing any other value to 0x40 leaves the restart output low and the status, mask and global enable unchanged.
- R10: Reads of 0x40, and of any unmapped offset, return zero. Unimplemented bits of the mapped registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_pulse | input | 6 | Single-cycle event pulses from the core |
| irq | output | 1 | Interrupt request level |
| core_rst | output | 1 | One-cycle restart pulse to the core |

## Verification
The hardest case to reach from the ports is a collision: a status write or key write that arrives in the same cycle as event pulses on the bits it touches. This is what tests the set-wins rule and the override by the key write. Random stimulus drives sparse event pulses alongside register writes. Those writes often carry the status value just read back, or the key itself. Directed steps then force the exact collision on a single bit and a near-miss key value.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register offsets (software-visible map)
    localparam int unsigned OFS_GIE   = 32'h1C;
    localparam int unsigned OFS_STAT  = 32'h20;
    localparam int unsigned OFS_MASK  = 32'h28;
    localparam int unsigned OFS_RKEY  = 32'h40;

    // Bit position of the global enable inside its register
    localparam int unsigned GIE_BIT   = 31;

    // Decoded write selects
    typedef struct packed {
        logic gie_we;
        logic stat_we;
        logic mask_we;
        logic rkey_we;
    } wr_sel_t;

    typedef enum logic [2:0] {
        RD_NONE, RD_GIE, RD_STAT, RD_MASK
    } rd_sel_e;

    function automatic wr_sel_t decode_wr(logic wr, int unsigned ofs);
        wr_sel_t s;
        s.gie_we  = wr && (ofs == OFS_GIE);
        s.stat_we = wr && (ofs == OFS_STAT);
        s.mask_we = wr && (ofs == OFS_MASK);
        s.rkey_we = wr && (ofs == OFS_RKEY);
        return s;
    endfunction

    function automatic rd_sel_e decode_rd(int unsigned ofs);
        case (ofs)
            OFS_GIE:  return RD_GIE;
            OFS_STAT: return RD_STAT;
            OFS_MASK: return RD_MASK;
            default:  return RD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/evt_status.sv
module evt_status #(
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               kill,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] clr,
    output logic [NUM_EVT-1:0] stat_q
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || kill)
                stat_q[i] <= 1'b0;
            else if (evt[i])
                stat_q[i] <= 1'b1;
            else if (clr[i])
                stat_q[i] <= 1'b0;
        end

        AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
            (evt[i] && !kill) |=> stat_q[i]);                       // R2 R4
        AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !evt[i] && !kill) |=> !stat_q[i]);           // R3
        AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && !evt[i] && !kill) |=> $stable(stat_q[i]));  // R3
    end

endmodule

// File: rtl/key_reset.sv
module key_reset #(
    parameter int               DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY   = 'h0A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              kill,
    output logic              core_rst
);

    assign kill = key_we && (wdata == KEY);

    always_ff @(posedge clk) begin
        if (rst)
            core_rst <= 1'b0;
        else
            core_rst <= kill;
    end

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int NUM_EVT = 6
) (
    input  logic               gie,
    input  logic [NUM_EVT-1:0] stat,
    input  logic [NUM_EVT-1:0] mask,
    output logic               irq
);

    logic [NUM_EVT:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_or
        assign chain[i+1] = chain[i] | (stat[i] & mask[i]);
    end

    assign irq = gie & chain[NUM_EVT];

endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
    import evt_irq_pkg::*;
#(
    parameter int                NUM_EVT = 6,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_KEY = 'h0A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq,
    output logic               core_rst
);

    localparam int PAD_W = DATA_W - NUM_EVT;

    wr_sel_t            wsel;
    rd_sel_e            rsel;
    logic               kill;
    logic               gie_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] stat_q;
    logic [NUM_EVT-1:0] clr_mask;

    assign wsel     = decode_wr(reg_wr, 32'(reg_addr));
    assign rsel     = decode_rd(32'(reg_addr));
    assign clr_mask = wsel.stat_we ? reg_wdata[NUM_EVT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            gie_q <= 1'b0;
        else if (wsel.gie_we)
            gie_q <= reg_wdata[GIE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst || kill)
            mask_q <= '0;
        else if (wsel.mask_we)
            mask_q <= reg_wdata[NUM_EVT-1:0];
    end

    evt_status #(.NUM_EVT(NUM_EVT)) u_status (
        .clk    (clk),
        .rst    (rst),
        .kill   (kill),
        .evt    (evt_pulse),
        .clr    (clr_mask),
        .stat_q (stat_q)
    );

    key_reset #(.DATA_W(DATA_W), .KEY(RST_KEY)) u_key (
        .clk      (clk),
        .rst      (rst),
        .key_we   (wsel.rkey_we),
        .wdata    (reg_wdata),
        .kill     (kill),
        .core_rst (core_rst)
    );

    irq_merge #(.NUM_EVT(NUM_EVT)) u_merge (
        .gie  (gie_q),
        .stat (stat_q),
        .mask (mask_q),
        .irq  (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (rsel)
            RD_GIE:  reg_rdata[GIE_BIT] = gie_q;
            RD_STAT: reg_rdata = {{PAD_W{1'b0}}, stat_q};
            RD_MASK: reg_rdata = {{PAD_W{1'b0}}, mask_q};
            default: reg_rdata = '0;
        endcase
    end

    AST_GIE_GATES: assert property (@(posedge clk) disable iff (rst)
        !gie_q |-> !irq);                                           // R6
    AST_KEY_WIPES: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (stat_q == '0 && mask_q == '0));               // R8
    AST_RST_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> $past(reg_wr && 32'(reg_addr) == OFS_RKEY
                           && reg_wdata == RST_KEY));               // R7 R9

endmodule

// File: tb/evt_irq_ctl_bench.sv
module evt_irq_ctl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [5:0]  evt_pulse;
    logic        irq;
    logic        core_rst;

    always #5 clk = ~clk;

    evt_irq_ctl u_evt_irq_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq(irq), .core_rst(core_rst)
    );

    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   done   = 0;

    logic [5:0] m_stat = '0;
    logic [5:0] m_mask = '0;
    logic       m_gie  = 1'b0;
    logic       m_rst  = 1'b0;

    function automatic logic exp_irq();
        return m_gie & |(m_stat & m_mask);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_wr = 1'b0; reg_addr = a; evt_pulse = '0;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    // model update for one clock edge
    task automatic model(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic [5:0] ev);
        logic key;
        logic [5:0] clr;
        key = wr && a == 8'h40 && d == 32'h0000000A;
        clr = (wr && a == 8'h20) ? d[5:0] : 6'h0;
        if (wr && a == 8'h1C) m_gie = d[31];
        if (key) begin
            m_stat = '0; m_mask = '0;
        end else begin
            m_stat = (m_stat & ~clr) | ev;
            if (wr && a == 8'h28) m_mask = d[5:0];
        end
        m_rst = key;
    endtask

    // one cycle: drive at negedge, clock edge, check outputs at following negedge
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic [5:0] ev);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_pulse = ev;
        @(posedge clk);
        model(wr, a, d, ev);
        @(negedge clk);
        chk({31'b0, core_rst}, {31'b0, m_rst}, "R7 R9 core_rst");
        chk({31'b0, irq}, {31'b0, exp_irq()}, "R5 R6 irq");
        peek(8'h20, {26'b0, m_stat}, "R2 R3 R4 status");
        peek(8'h28, {26'b0, m_mask}, "R8 R9 mask");
        peek(8'h1C, {m_gie, 31'b0}, "R8 R9 gie");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; evt_pulse = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk({30'b0, irq, core_rst}, 32'h0, "R1 outputs");
        peek(8'h20, 32'h0, "R1 status");
        peek(8'h28, 32'h0, "R1 mask");
        peek(8'h1C, 32'h0, "R1 gie");

        // R2: events latch with mask clear and gie clear (R6: irq low)
        cyc(0, 8'h00, 0, 6'b100001);
        cyc(0, 8'h00, 0, 6'b000100);
        cyc(1, 8'h28, 32'hFFFF_FF24, 0);          // R5 mask bits 2,5
        chk({31'b0, irq}, 32'h0, "R6 gie off keeps irq low");
        cyc(1, 8'h1C, 32'h8000_0000, 0);          // R5 irq now high
        chk({31'b0, irq}, 32'h1, "R5 irq raised");
        // R3 write back of read value clears exactly those bits
        cyc(1, 8'h20, 32'h0000_0005, 0);
        peek(8'h20, 32'h20, "R3 w1c leaves bit5");
        // R4 collision: clear bit5 and event bit5 in the same cycle
        cyc(1, 8'h20, 32'h0000_0020, 6'b100000);
        peek(8'h20, 32'h20, "R4 set wins");
        // R9 near-miss keys
        cyc(1, 8'h40, 32'h0000_000B, 0);
        cyc(1, 8'h40, 32'h0000_010A, 0);
        peek(8'h20, 32'h20, "R9 status untouched");
        // R10 readback of key reg and unmapped
        peek(8'h40, 32'h0, "R10 key reg reads zero");
        peek(8'h24, 32'h0, "R10 unmapped reads zero");
        // R7 R8 key with a colliding event
        cyc(1, 8'h40, 32'h0000_000A, 6'b011000);
        chk({31'b0, core_rst}, 32'h1, "R7 pulse high");
        peek(8'h20, 32'h0, "R8 status wiped");
        peek(8'h1C, 32'h8000_0000, "R8 gie kept");
        cyc(0, 8'h00, 0, 0);
        chk({31'b0, core_rst}, 32'h0, "R7 pulse one cycle");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        w;
            logic [5:0]  ev;
            int          r;
            r = $urandom_range(0, 4);
            a = (r == 0) ? 8'h1C : (r == 1) ? 8'h20 : (r == 2) ? 8'h28 :
                (r == 3) ? 8'h40 : 8'h44;
            w = ($urandom_range(0, 1) == 1);
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = {26'b0, m_stat};
            if (a == 8'h40 && $urandom_range(0, 3) == 0) d = 32'h0000_000A;
            ev = ($urandom_range(0, 2) == 0) ? 6'($urandom()) : 6'h0;
            cyc(w, a, d, ev);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule